// File: doc/BRIEF.md
# NAND Parameter Page Validator

This block sits behind a flash controller that has already issued the bus cycles for an identifier read and a parameter page read. It receives the returned bytes as a stream qualified by a valid strobe. The first four bytes after a start pulse are the identifier. The bytes after them are the redundant 256-byte copies of the parameter page, sent one after another. Each copy is written into its own slot of internal storage while a 16-bit CRC runs over it. The first copy whose CRC matches is chosen, and the block finishes at once.

If every copy fails its CRC, the block makes one more pass over the storage. At each byte position it takes a bitwise majority vote across the copies and writes the result back into slot 0. The rebuilt page is CRC-checked again. When the block finishes it raises a done flag, an identifier-ok flag, a pass flag, the index of the chosen copy and a decoded revision level. A combinational read port then returns any byte of the chosen page.

Top module: `param_page_validator`

## Requirements
- R1: After `start`, the first four accepted bytes must be 0x4F, 0x4E, 0x46, 0x49 in that order. On any mismatch the block sets `done`=1, `onfi_ok`=0 and `pass`=0 in the cycle after the fourth byte, and accepts no page bytes.
- R2: The page check is a 16-bit CRC with polynomial 0x8005, seeded with 0x4F4E at the start of each copy. It is processed MSB first, and each byte is XORed into bits 15:8 before eight shift steps. It covers bytes 0 to 253. It is compared with byte 254 (low half) and byte 255 (high half).
- R3: The first copy (index 0, 1 or 2) that passes R2 is chosen. In the cycle after its last byte, `done`=1, `pass`=1 and `sel_copy` holds its index. No later copy is consumed.
- R4: If all three copies fail, `sel_copy` becomes 3. The rebuilt page has a bit set wherever at least two of the three copies have it set, and it is readable through `rd_addr`/`rd_data`.
- R5: If the rebuilt page fails R2, the block finishes with `done`=1 and `pass`=0.
- R6: The revision word is byte 4 (low) and byte 5 (high) of the chosen page. `rev_level` takes the highest set bit among bit 5 (code 5), bit 4 (code 4), bit 3 (code 3), bit 2 (code 2) and bit 1 (code 1). It is 0 when none of these bits is set or when `pass`=0.
- R7: Once `done`=1, further bytes have no effect on any output until the next `start`. A `start` pulse at any time, even partway through a copy, restarts the whole sequence.
- R8: After reset, `done`, `onfi_ok`, `pass`, `sel_copy` and `rev_level` are all 0.
- R9: `rd_data` combinationally returns byte `rd_addr` of the chosen or rebuilt page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a new identification |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_byte | input | 8 | Identifier and page bytes, in arrival order |
| rd_addr | input | 8 | Byte address into the chosen page |
| done | output | 1 | Sequence finished |
| onfi_ok | output | 1 | Identifier bytes matched |
| pass | output | 1 | A page passed its CRC |
| sel_copy | output | 2 | Index of the chosen copy, 3 for the rebuilt page |
| rev_level | output | 3 | Decoded revision level, 0 = unsupported |
| rd_data | output | 8 | Byte of the chosen page at `rd_addr` |

## Verification
The assertions assume that `start` is a single-cycle pulse that is not raised together with `in_valid`. They also assume that, after a start, the source sends only a full identifier followed by whole 256-byte copies. The stimulus gives `start` its own cycle, with `in_valid` low. Between bytes it inserts idle cycles at random. It stops sending copies as soon as its own model predicts a pass. The one exception is a deliberate truncated copy, which is cut off by a new start.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int PAGE_BYTES = 256;
    localparam int NCOPY      = 3;
    localparam int ID_BYTES   = 4;
    localparam logic [15:0] CRC_SEED = 16'h4F4E;
    localparam logic [15:0] CRC_POLY = 16'h8005;
    localparam int REV_LO_POS = 4;
    localparam int REV_HI_POS = 5;
    localparam int SEL_W      = $clog2(NCOPY + 1);
    localparam int COPY_W     = $clog2(NCOPY);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ID, ST_PAGE, ST_VOTE, ST_DONE
    } seq_state_t;

    typedef logic [2:0] rev_code_t;

    typedef struct packed {
        logic      done;
        logic      onfi_ok;
        logic      pass;
        rev_code_t rev;
    } verdict_t;

    function automatic logic [15:0] crc_byte(input logic [15:0] cur, input logic [7:0] b);
        logic [15:0] c;
        c = cur ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

    function automatic rev_code_t rev_decode(input logic [15:0] w);
        if (w[5])      return 3'd5;
        else if (w[4]) return 3'd4;
        else if (w[3]) return 3'd3;
        else if (w[2]) return 3'd2;
        else if (w[1]) return 3'd1;
        else           return 3'd0;
    endfunction

    function automatic logic [7:0] id_byte(input logic [1:0] k);
        case (k)
            2'd0:    return 8'h4F;
            2'd1:    return 8'h4E;
            2'd2:    return 8'h46;
            default: return 8'h49;
        endcase
    endfunction
endpackage

// File: rtl/pp_crc16.sv
module pp_crc16
    import pp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || load) crc <= CRC_SEED;
        else if (en)     crc <= crc_byte(crc, din);
    end

    // R2: every copy starts from the seed
    p_reseed_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (crc == CRC_SEED));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> $stable(crc));
endmodule

// File: rtl/pp_page_ram.sv
module pp_page_ram #(
    parameter int NCOPY      = 3,
    parameter int PAGE_BYTES = 256,
    localparam int AW = $clog2(PAGE_BYTES),
    localparam int CW = $clog2(NCOPY)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [CW-1:0]        wr_copy,
    input  logic [AW-1:0]        wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [AW-1:0]        vote_addr,
    output logic [NCOPY*8-1:0]   vote_all,
    input  logic [CW-1:0]        usr_copy,
    input  logic [AW-1:0]        usr_addr,
    output logic [7:0]           usr_data
);
    logic [7:0] usr_each [NCOPY];

    for (genvar g = 0; g < NCOPY; g++) begin : g_slot
        logic [7:0] mem [PAGE_BYTES];
        always_ff @(posedge clk) begin
            if (we && wr_copy == CW'(g)) mem[wr_addr] <= wr_data;
        end
        assign vote_all[g*8 +: 8] = mem[vote_addr];
        assign usr_each[g]        = mem[usr_addr];
    end

    always_comb begin
        usr_data = '0;
        for (int i = 0; i < NCOPY; i++) begin
            if (usr_copy == CW'(i)) usr_data = usr_each[i];
        end
    end
endmodule

// File: rtl/pp_majority.sv
module pp_majority #(
    parameter int NCOPY = 3,
    localparam int CNTW = $clog2(NCOPY + 1)
) (
    input  logic [NCOPY*8-1:0] bytes_in,
    output logic [7:0]         voted
);
    for (genvar b = 0; b < 8; b++) begin : g_bit
        logic [CNTW-1:0] ones;
        always_comb begin
            ones = '0;
            for (int k = 0; k < NCOPY; k++) ones = ones + CNTW'(bytes_in[k*8 + b]);
        end
        assign voted[b] = (ones > CNTW'(NCOPY / 2));
    end
endmodule

// File: rtl/param_page_validator.sv
module param_page_validator
    import pp_pkg::*;
#(
    parameter int PG_BYTES = PAGE_BYTES,
    localparam int AW = $clog2(PG_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [AW-1:0]     rd_addr,
    output logic              done,
    output logic              onfi_ok,
    output logic              pass,
    output logic [SEL_W-1:0]  sel_copy,
    output logic [2:0]        rev_level,
    output logic [7:0]        rd_data
);
    localparam logic [AW-1:0] LAST_IDX = AW'(PG_BYTES - 1);
    localparam logic [AW-1:0] CRCLO_IDX = AW'(PG_BYTES - 2);
    localparam logic [AW-1:0] ID_LAST  = AW'(ID_BYTES - 1);

    seq_state_t          state;
    verdict_t            res;
    logic [SEL_W-1:0]    sel;
    logic [AW-1:0]       idx;
    logic [COPY_W-1:0]   copy;
    logic                id_good;
    logic [7:0]          crc_lo, rev_lo, rev_hi;

    logic [NCOPY*8-1:0]  vote_all;
    logic [7:0]          voted, data_now;
    logic [15:0]         crc;
    logic                step, crc_en, crc_load, crc_ok_now, id_match;
    logic [COPY_W-1:0]   wr_copy, usr_copy;

    assign step       = (state == ST_PAGE && in_valid) || (state == ST_VOTE);
    assign data_now   = (state == ST_VOTE) ? voted : in_byte;
    assign crc_en     = step && (idx < CRCLO_IDX);
    assign crc_load   = start || (step && idx == LAST_IDX);
    assign crc_ok_now = ({data_now, crc_lo} == crc);
    assign id_match   = (in_byte == id_byte(idx[1:0]));
    assign wr_copy    = (state == ST_VOTE) ? '0 : copy;
    assign usr_copy   = (sel == SEL_W'(NCOPY)) ? '0 : COPY_W'(sel);

    pp_crc16 u_crc (
        .clk(clk), .rst(rst), .load(crc_load), .en(crc_en),
        .din(data_now), .crc(crc)
    );

    pp_page_ram #(.NCOPY(NCOPY), .PAGE_BYTES(PG_BYTES)) u_ram (
        .clk(clk), .we(step), .wr_copy(wr_copy), .wr_addr(idx), .wr_data(data_now),
        .vote_addr(idx), .vote_all(vote_all),
        .usr_copy(usr_copy), .usr_addr(rd_addr), .usr_data(rd_data)
    );

    pp_majority #(.NCOPY(NCOPY)) u_vote (
        .bytes_in(vote_all), .voted(voted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            res     <= '0;
            sel     <= '0;
            idx     <= '0;
            copy    <= '0;
            id_good <= 1'b0;
            crc_lo  <= '0;
            rev_lo  <= '0;
            rev_hi  <= '0;
        end else if (start) begin
            state   <= ST_ID;
            res     <= '0;
            sel     <= '0;
            idx     <= '0;
            copy    <= '0;
            id_good <= 1'b1;
        end else begin
            if (step) begin
                if (idx == AW'(REV_LO_POS)) rev_lo <= data_now;
                if (idx == AW'(REV_HI_POS)) rev_hi <= data_now;
                if (idx == CRCLO_IDX)       crc_lo <= data_now;
            end
            case (state)
                ST_ID: if (in_valid) begin
                    if (!id_match) id_good <= 1'b0;
                    if (idx == ID_LAST) begin
                        idx <= '0;
                        if (id_good && id_match) begin
                            state       <= ST_PAGE;
                            res.onfi_ok <= 1'b1;
                        end else begin
                            state    <= ST_DONE;
                            res.done <= 1'b1;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_PAGE: if (in_valid) begin
                    if (idx == LAST_IDX) begin
                        idx <= '0;
                        if (crc_ok_now) begin
                            state    <= ST_DONE;
                            res.done <= 1'b1;
                            res.pass <= 1'b1;
                            res.rev  <= rev_decode({rev_hi, rev_lo});
                            sel      <= SEL_W'(copy);
                        end else if (copy == COPY_W'(NCOPY - 1)) begin
                            state <= ST_VOTE;
                        end else begin
                            copy <= copy + 1'b1;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_VOTE: begin
                    if (idx == LAST_IDX) begin
                        idx      <= '0;
                        state    <= ST_DONE;
                        res.done <= 1'b1;
                        res.pass <= crc_ok_now;
                        res.rev  <= crc_ok_now ? rev_decode({rev_hi, rev_lo}) : 3'd0;
                        sel      <= SEL_W'(NCOPY);
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done      = res.done;
    assign onfi_ok   = res.onfi_ok;
    assign pass      = res.pass;
    assign rev_level = res.rev;
    assign sel_copy  = sel;

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    p_result_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(res) && $stable(sel)));
    p_pass_needs_id_r1: assert property (@(posedge clk) disable iff (rst)
        pass |-> (onfi_ok && done));
    p_vote_ends_rebuilt_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VOTE && !start) |=> (state == ST_VOTE || (done && sel_copy == SEL_W'(NCOPY))));
    p_rev_range_r6: assert property (@(posedge clk) disable iff (rst)
        (rev_level <= 3'd5) && (!pass -> rev_level == 3'd0));
    p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !pass && !onfi_ok));
endmodule

// File: tb/tb_param_page_validator.sv
module tb_param_page_validator;
    logic clk = 0, rst = 1, start = 0, in_valid = 0;
    logic [7:0] in_byte = 0, rd_addr = 0;
    logic done, onfi_ok, pass;
    logic [1:0] sel_copy;
    logic [2:0] rev_level;
    logic [7:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] pg [3][256];
    logic [7:0] gold [256];
    int exp_sel, n_send;
    logic exp_pass;
    logic [2:0] exp_rev;

    always #5 clk = ~clk;

    param_page_validator dut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_byte(in_byte),
        .rd_addr(rd_addr), .done(done), .onfi_ok(onfi_ok), .pass(pass),
        .sel_copy(sel_copy), .rev_level(rev_level), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] bench_crc(input logic [7:0] p [256]);
        logic [15:0] c = 16'h4F4E;
        for (int i = 0; i < 254; i++)
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[15] ^ p[i][b];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h8005;
            end
        return c;
    endfunction

    function automatic logic page_ok(input logic [7:0] p [256]);
        return bench_crc(p) == {p[255], p[254]};
    endfunction

    function automatic logic [2:0] bench_rev(input logic [15:0] w);
        for (int b = 5; b >= 1; b--) if (w[b]) return 3'(b);
        return 3'd0;
    endfunction

    task automatic make_good(input int c, input logic [15:0] rev);
        logic [7:0] t [256];
        logic [15:0] k;
        for (int i = 0; i < 256; i++) t[i] = 8'($urandom);
        t[4] = rev[7:0];
        t[5] = rev[15:8];
        k = bench_crc(t);
        t[254] = k[7:0];
        t[255] = k[15:8];
        for (int i = 0; i < 256; i++) pg[c][i] = t[i];
    endtask

    task automatic copy_page(input int dst, input int src);
        for (int i = 0; i < 256; i++) pg[dst][i] = pg[src][i];
    endtask

    task automatic flip(input int c, input int pos, input int bitn);
        pg[c][pos][bitn] = ~pg[c][pos][bitn];
    endtask

    task automatic predict();
        logic [7:0] t [256];
        exp_sel = 3; n_send = 3;
        for (int c = 0; c < 3 && exp_sel == 3; c++) begin
            for (int i = 0; i < 256; i++) t[i] = pg[c][i];
            if (page_ok(t)) begin exp_sel = c; n_send = c + 1; end
        end
        for (int i = 0; i < 256; i++)
            gold[i] = (exp_sel < 3) ? pg[exp_sel][i]
                    : ((pg[0][i] & pg[1][i]) | (pg[0][i] & pg[2][i]) | (pg[1][i] & pg[2][i]));
        exp_pass = page_ok(gold);
        exp_rev  = exp_pass ? bench_rev({gold[5], gold[4]}) : 3'd0;
    endtask

    task automatic push(input logic [7:0] b);
        if ($urandom % 6 == 0) begin @(negedge clk); in_valid = 0; end
        @(negedge clk);
        in_valid = 1;
        in_byte  = b;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        in_valid = 0;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic send_id(input logic bad);
        logic [7:0] idv [4];
        idv[0] = 8'h4F; idv[1] = 8'h4E; idv[2] = 8'h46; idv[3] = 8'h49;
        if (bad) idv[$urandom % 4] ^= 8'h20;
        for (int i = 0; i < 4; i++) push(idv[i]);
        idle();
    endtask

    task automatic wait_done();
        for (int i = 0; i < 600 && !done; i++) @(negedge clk);
    endtask

    task automatic check_page(input string req);
        int bad = 0, first = -1;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            rd_addr = 8'(a);
            #1;
            if (rd_data !== gold[a]) begin bad++; if (first < 0) first = a; end
        end
        chk(req, "page mismatching bytes", bad, 0);
    endtask

    // full run for a valid identifier
    task automatic run_pages(input string req);
        predict();
        pulse_start();
        send_id(1'b0);
        chk("R1", "onfi_ok after good id", onfi_ok, 1);
        for (int c = 0; c < n_send; c++)
            for (int i = 0; i < 256; i++) push(pg[c][i]);
        idle();
        wait_done();
        chk(req, "done", done, 1);
        chk(req, "pass (R2/R5)", pass, exp_pass);
        chk(req, "sel_copy (R3/R4)", sel_copy, exp_sel);
        chk("R6", "rev_level", rev_level, exp_rev);
        check_page("R9");
        // R7: trailing bytes are ignored
        for (int i = 0; i < 40; i++) push(8'($urandom));
        idle();
        chk("R7", "pass after extra bytes", pass, exp_pass);
        chk("R7", "sel after extra bytes", sel_copy, exp_sel);
        chk("R7", "rev after extra bytes", rev_level, exp_rev);
        @(negedge clk); rd_addr = 8'd4; #1;
        chk("R7", "page byte 4 after extra bytes", rd_data, gold[4]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R8 reset state
        chk("R8", "done", done, 0);
        chk("R8", "pass", pass, 0);
        chk("R8", "onfi_ok", onfi_ok, 0);
        chk("R8", "sel_copy", sel_copy, 0);
        chk("R8", "rev_level", rev_level, 0);

        // R1 bad identifier
        pulse_start();
        send_id(1'b1);
        chk("R1", "done after bad id", done, 1);
        chk("R1", "onfi_ok after bad id", onfi_ok, 0);
        chk("R1", "pass after bad id", pass, 0);
        make_good(0, 16'h0002);
        for (int i = 0; i < 256; i++) push(pg[0][i]);
        idle();
        chk("R1", "pass after page bytes on bad id", pass, 0);

        // R3 copy 0 good, top priority bit
        make_good(0, 16'h0022);
        copy_page(1, 0); copy_page(2, 0);
        run_pages("R3");

        // R7 restart mid-copy, then R3 copy 1 good
        make_good(1, 16'h0004);
        copy_page(0, 1); flip(0, 100, 3); copy_page(2, 1);
        pulse_start();
        send_id(1'b0);
        for (int i = 0; i < 120; i++) push(pg[1][i]);
        run_pages("R3");

        // R2 corrupt CRC byte, copy 2 good, unsupported revision
        make_good(2, 16'h0001);
        copy_page(0, 2); flip(0, 255, 0);
        copy_page(1, 2); flip(1, 254, 7);
        run_pages("R2");

        // R4 majority recovery
        make_good(0, 16'h0008);
        copy_page(1, 0); copy_page(2, 0);
        flip(0, 10, 0); flip(1, 11, 1); flip(2, 12, 2);
        run_pages("R4");

        // R5 majority fails
        make_good(0, 16'h0010);
        copy_page(1, 0); copy_page(2, 0);
        flip(0, 20, 5); flip(1, 20, 5); flip(2, 30, 1);
        run_pages("R5");

        // random mix
        for (int it = 0; it < 14; it++) begin
            int mode = int'($urandom % 5);
            make_good(0, 16'($urandom));
            copy_page(1, 0); copy_page(2, 0);
            for (int c = 0; c < 3; c++)
                if (c < mode) flip(c, int'($urandom % 256), int'($urandom % 8));
            if (mode == 4) flip(int'($urandom % 3), int'($urandom % 256), int'($urandom % 8));
            run_pages("R3");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule